// File: doc/BRIEF.md
# Change-of-State Input Interrupt Unit

This block samples a 32-bit parallel digital input port and raises one interrupt line when a chosen subset of the inputs changes state. Only channels 4 through 19 can take part in interrupt generation. Each of these channels has two per-channel mask bits. One mask selects rising edges or a high level. The other selects falling edges or a low level.

Two combining modes are available. In edge mode (OR), any enabled edge on any enabled channel raises the event. In level mode (AND), the event is raised only when every selected channel sits at its requested level. After a level-mode event, the trigger stays blocked until a selected channel changes level.

Software talks to the unit through a small 32-bit register interface. It can read the raw synchronised input. It can program both masks and the control word. It reads the latched status to learn which channels were high at the event, and that read also acknowledges the event. A disable-then-enable write on the control word acknowledges the event too.

Top module: `cos_irq_unit`

## Requirements
- R1: After reset `irq` is low and every register (offsets 0x00, 0x04, 0x08, 0x0C, 0x10) reads zero while the inputs are zero.
- R2: The rising/high mask lives at offset 0x04 and the falling/low mask at 0x08. Bits outside [19:4] are stored as zero (each mask reads back at most 0x000FFFF0), and inputs outside [19:4] never cause an interrupt.
- R3: Offset 0x00 returns the input port after a two-flop synchroniser. A change applied between clock edges is visible after the second rising edge, not after the first.
- R4: The control word at offset 0x10 holds the enable flag in bit 2 and the mode flag in bit 1 (1 = AND/level, 0 = OR/edge). All other bits read as zero.
- R5: In OR mode, a rising edge on a channel set in the 0x04 mask raises `irq` on the third rising clock edge after the input change, and not earlier.
- R6: In OR mode, a falling edge fires only for channels set in the 0x08 mask. A channel set in both masks fires on both edges, and a channel set only in 0x04 ignores falling edges.
- R7: In AND mode, an event fires only when every channel in either mask is at its level (high for 0x04 bits, low for 0x08 bits). A partial match does not fire.
- R8: After an AND-mode event, no further event fires until a selected channel changes level, even though the condition still holds. Changes on unselected channels do not re-arm the trigger.
- R9: Offset 0x0C returns the synchronised input bits [19:4] captured at the event, plus the pending flag in bit 0. Reading it clears the pending flag, so `irq` falls.
- R10: Writing the control word with bit 2 clear discards a pending event, and `irq` drops. Enabling again afterwards does not bring the event back.
- R11: While the enable flag is clear, input activity latches no event, and the status stays zero.
- R12: `irq` is high exactly while an event is pending and the enable flag is set.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe (a status read clears the pending flag) |
| addr | input | 5 | Byte offset of the register |
| wrData | input | 32 | Write data |
| rdData | output | 32 | Read data, combinational from `addr` |
| dIn | input | 32 | Asynchronous digital input port |
| irq | output | 1 | Level interrupt line |

## Verification
The edge-mode tests use three kinds of single-channel transitions: a rise on a high-mask channel, a fall on that same channel, and a channel set in both masks. These show whether each mask steers the right edge direction. A second enabled channel at the top of the range (19) checks that the OR picks up any channel. Toggles on channels 3, 20 and 31 with all mask bits written check the range clamp.

The level-mode test drives first a partial match, then a full match, then a held match. These separate the AND combination from the re-arm rule. The test then toggles an unselected channel and finally a selected one, which shows that only selected channels can release the trigger. The disabled, acknowledge and input-latency tests cover the remaining paths.

// File: rtl/cos_pkg.sv
package cos_pkg;
  // Register byte offsets
  localparam int OFF_INPUT  = 'h00;
  localparam int OFF_MASKHI = 'h04;
  localparam int OFF_MASKLO = 'h08;
  localparam int OFF_STATUS = 'h0C;
  localparam int OFF_CTRL   = 'h10;

  // Control word and status word bit positions
  localparam int BIT_ENABLE = 2;
  localparam int BIT_ANDSEL = 1;
  localparam int BIT_PEND   = 0;

  // Strobes from the control side to the datapath
  typedef struct packed {
    logic statusRd;  // status register read this cycle
    logic ackWr;     // control write with enable clear
  } cosStrobe_t;
endpackage

// File: rtl/cos_ctrl.sv
module cos_ctrl
  import cos_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int LO_CH  = 4,
  parameter int HI_CH  = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] syncIn,
  input  logic [DATA_W-1:0] capState,
  input  logic              pending,
  output logic [DATA_W-1:0] maskHi,
  output logic [DATA_W-1:0] maskLo,
  output logic              enable,
  output logic              andMode,
  output cosStrobe_t        strb
);
  localparam logic [DATA_W-1:0] CH_MASK =
    ((({DATA_W{1'b1}}) >> (DATA_W - 1 - HI_CH)) >> LO_CH) << LO_CH;

  logic selIn, selHi, selLo, selStat, selCtrl;

  assign selIn   = (addr == ADDR_W'(OFF_INPUT));
  assign selHi   = (addr == ADDR_W'(OFF_MASKHI));
  assign selLo   = (addr == ADDR_W'(OFF_MASKLO));
  assign selStat = (addr == ADDR_W'(OFF_STATUS));
  assign selCtrl = (addr == ADDR_W'(OFF_CTRL));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskHi  <= '0;
      maskLo  <= '0;
      enable  <= 1'b0;
      andMode <= 1'b0;
    end else if (wrEn) begin
      if (selHi)   maskHi  <= wrData & CH_MASK;
      if (selLo)   maskLo  <= wrData & CH_MASK;
      if (selCtrl) begin
        enable  <= wrData[BIT_ENABLE];
        andMode <= wrData[BIT_ANDSEL];
      end
    end
  end

  always_comb begin
    strb.statusRd = rdEn && selStat;
    strb.ackWr    = wrEn && selCtrl && !wrData[BIT_ENABLE];
  end

  always_comb begin
    rdData = '0;
    if (selIn)   rdData = syncIn;
    if (selHi)   rdData = maskHi;
    if (selLo)   rdData = maskLo;
    if (selStat) begin
      rdData           = capState & CH_MASK;
      rdData[BIT_PEND] = pending;
    end
    if (selCtrl) begin
      rdData[BIT_ENABLE] = enable;
      rdData[BIT_ANDSEL] = andMode;
    end
  end

  AST_MASK_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    ((maskHi | maskLo) & ~CH_MASK) == '0);  // R2

  AST_ACK_DISABLES: assert property (@(posedge clk) disable iff (!rstN)
    (wrEn && selCtrl && !wrData[BIT_ENABLE]) |=> !enable);  // R10
endmodule

// File: rtl/cos_datapath.sv
module cos_datapath
  import cos_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int LO_CH  = 4,
  parameter int HI_CH  = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] dIn,
  input  logic [DATA_W-1:0] maskHi,
  input  logic [DATA_W-1:0] maskLo,
  input  logic              enable,
  input  logic              andMode,
  input  cosStrobe_t        strb,
  output logic [DATA_W-1:0] syncIn,
  output logic [DATA_W-1:0] capState,
  output logic              pending
);
  localparam logic [DATA_W-1:0] CH_MASK =
    ((({DATA_W{1'b1}}) >> (DATA_W - 1 - HI_CH)) >> LO_CH) << LO_CH;

  logic [DATA_W-1:0] meta, prevQ, rise, fall, orHit, andOk, selMask;
  logic              armed, anyChg, andCond, hit;

  // two-flop synchroniser plus one history stage for edge detection
  always_ff @(posedge clk) begin
    if (!rstN) begin
      meta   <= '0;
      syncIn <= '0;
      prevQ  <= '0;
    end else begin
      meta   <= dIn;
      syncIn <= meta;
      prevQ  <= syncIn;
    end
  end

  assign rise    = syncIn & ~prevQ;
  assign fall    = ~syncIn & prevQ;
  assign selMask = (maskHi | maskLo) & CH_MASK;

  for (genvar i = 0; i < DATA_W; i++) begin : g_ch
    if (i >= LO_CH && i <= HI_CH) begin : g_live
      assign orHit[i] = (rise[i] & maskHi[i]) | (fall[i] & maskLo[i]);
      assign andOk[i] = (!maskHi[i] || syncIn[i]) && (!maskLo[i] || !syncIn[i]);
    end else begin : g_dead
      assign orHit[i] = 1'b0;
      assign andOk[i] = 1'b1;
    end
  end

  assign anyChg  = |((rise | fall) & selMask);
  assign andCond = (&andOk) && (|selMask);
  assign hit     = enable && (andMode ? (andCond && armed) : (|orHit));

  always_ff @(posedge clk) begin
    if (!rstN) begin
      armed <= 1'b1;
    end else if (!enable || !andMode) begin
      armed <= 1'b1;
    end else if (hit) begin
      armed <= 1'b0;
    end else if (anyChg) begin
      armed <= 1'b1;
    end
  end

  // a new event wins over a same-cycle acknowledge
  always_ff @(posedge clk) begin
    if (!rstN) begin
      pending  <= 1'b0;
      capState <= '0;
    end else if (hit) begin
      pending  <= 1'b1;
      capState <= syncIn & CH_MASK;
    end else if (strb.statusRd || strb.ackWr) begin
      pending  <= 1'b0;
    end
  end

  AST_CLEAR_ON_ACK: assert property (@(posedge clk) disable iff (!rstN)
    ((strb.statusRd || strb.ackWr) && !hit) |=> !pending);  // R9

  AST_CAP_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (pending && !hit) |=> $stable(capState));  // R9

  AST_DISABLED_QUIET: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !$rose(pending));  // R11

  AST_AND_BLOCKED: assert property (@(posedge clk) disable iff (!rstN)
    (enable && andMode && !armed && !anyChg) |=> !$rose(pending));  // R8

  AST_OR_NEEDS_EDGE: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !andMode && ((rise | fall) == '0)) |=> !$rose(pending));  // R5
endmodule

// File: rtl/cos_irq_unit.sv
module cos_irq_unit
  import cos_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 5,
  parameter int LO_CH  = 4,
  parameter int HI_CH  = 19
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  input  logic [DATA_W-1:0] dIn,
  output logic              irq
);
  cosStrobe_t        strb;
  logic [DATA_W-1:0] syncIn, capState, maskHi, maskLo;
  logic              pending, enable, andMode;

  cos_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .LO_CH(LO_CH), .HI_CH(HI_CH)) u_ctrl (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .syncIn(syncIn), .capState(capState),
    .pending(pending), .maskHi(maskHi), .maskLo(maskLo), .enable(enable),
    .andMode(andMode), .strb(strb)
  );

  cos_datapath #(.DATA_W(DATA_W), .LO_CH(LO_CH), .HI_CH(HI_CH)) u_dp (
    .clk(clk), .rstN(rstN), .dIn(dIn), .maskHi(maskHi), .maskLo(maskLo),
    .enable(enable), .andMode(andMode), .strb(strb), .syncIn(syncIn),
    .capState(capState), .pending(pending)
  );

  assign irq = pending && enable;

  AST_IRQ_OFF_AFTER_DISABLE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(enable) |-> !irq);  // R12
endmodule

// File: tb/cos_irq_unit_tb.sv
`timescale 1ns/1ps
module cos_irq_unit_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        wrEn = 1'b0;
  logic        rdEn = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [31:0] dIn = '0;
  logic        irq;
  int nChecks = 0;
  int nFails = 0;

  always #4 clk = ~clk;

  cos_irq_unit u_dut (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .dIn(dIn), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=0x%08h expected=0x%08h", tag, act, exp);
    end
  endtask

  task automatic waitCyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    wrEn = 1'b1; addr = a; wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [4:0] a, output logic [31:0] v);
    rdEn = 1'b1; addr = a;
    #1 v = rdData;
    @(negedge clk);
    rdEn = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; dIn = '0; wrEn = 1'b0; rdEn = 1'b0;
    waitCyc(3);
    rstN = 1'b1;
    @(negedge clk);
  endtask

  task automatic testReset();
    logic [31:0] v;
    doReset();
    check("R1 irq after reset", {31'd0, irq}, 32'd0);
    for (int k = 0; k <= 16; k += 4) begin
      busRead(5'(k), v);
      check("R1 register after reset", v, 32'd0);
    end
  endtask

  task automatic testInputAndCtrl();
    logic [31:0] v;
    doReset();
    dIn = 32'hA5A5_0F0F;
    waitCyc(1);
    busRead(5'h00, v);
    check("R3 input not yet after one edge", v, 32'd0);
    busRead(5'h00, v);
    check("R3 input after two edges", v, 32'hA5A5_0F0F);
    busWrite(5'h10, 32'hFFFF_FFFF);
    busRead(5'h10, v);
    check("R4 control readback", v, 32'h6);
    busWrite(5'h10, 32'h4);
    busRead(5'h10, v);
    check("R4 control enable only", v, 32'h4);
  endtask

  task automatic testMaskRange();
    logic [31:0] v;
    doReset();
    busWrite(5'h04, 32'hFFFF_FFFF);
    busRead(5'h04, v);
    check("R2 high mask clamp", v, 32'h000F_FFF0);
    busWrite(5'h08, 32'hFFFF_FFFF);
    busRead(5'h08, v);
    check("R2 low mask clamp", v, 32'h000F_FFF0);
    busWrite(5'h10, 32'h4);
    dIn[3] = 1'b1; dIn[20] = 1'b1; dIn[31] = 1'b1;
    waitCyc(4);
    check("R2 out-of-range rise ignored", {31'd0, irq}, 32'd0);
    dIn[3] = 1'b0; dIn[20] = 1'b0;
    waitCyc(4);
    check("R2 out-of-range fall ignored", {31'd0, irq}, 32'd0);
  endtask

  task automatic testOrEdges();
    logic [31:0] v;
    doReset();
    busWrite(5'h04, 32'h0008_0010);
    busWrite(5'h10, 32'h4);
    dIn[4] = 1'b1;
    waitCyc(2);
    check("R5 irq not early", {31'd0, irq}, 32'd0);
    waitCyc(1);
    check("R5 irq on rise", {31'd0, irq}, 32'd1);
    busRead(5'h0C, v);
    check("R9 status after rise", v, 32'h0000_0011);
    check("R9 irq cleared by read", {31'd0, irq}, 32'd0);
    dIn[4] = 1'b0;
    waitCyc(4);
    check("R6 fall ignored with high mask only", {31'd0, irq}, 32'd0);
    dIn[19] = 1'b1;
    waitCyc(3);
    check("R5 any channel fires (19)", {31'd0, irq}, 32'd1);
    busRead(5'h0C, v);
    check("R9 status channel 19", v, 32'h0008_0001);
    busWrite(5'h08, 32'h0000_0010);
    dIn[4] = 1'b1;
    waitCyc(3);
    check("R6 both masks rise", {31'd0, irq}, 32'd1);
    busRead(5'h0C, v);
    check("R6 status both rise", v, 32'h0008_0011);
    dIn[4] = 1'b0;
    waitCyc(3);
    check("R6 both masks fall", {31'd0, irq}, 32'd1);
    busRead(5'h0C, v);
    check("R6 status both fall", v, 32'h0008_0001);
  endtask

  task automatic testAndMode();
    logic [31:0] v;
    doReset();
    busWrite(5'h04, 32'h0000_0010);
    busWrite(5'h08, 32'h0000_0020);
    busWrite(5'h10, 32'h6);
    dIn[5] = 1'b1; dIn[4] = 1'b1;
    waitCyc(4);
    check("R7 partial match no fire", {31'd0, irq}, 32'd0);
    dIn[5] = 1'b0;
    waitCyc(3);
    check("R7 full match fires", {31'd0, irq}, 32'd1);
    busRead(5'h0C, v);
    check("R7 status at level match", v, 32'h0000_0011);
    waitCyc(4);
    check("R8 held match blocked", {31'd0, irq}, 32'd0);
    dIn[9] = 1'b1;
    waitCyc(4);
    check("R8 unselected change no rearm", {31'd0, irq}, 32'd0);
    dIn[4] = 1'b0;
    waitCyc(4);
    check("R8 change breaks match", {31'd0, irq}, 32'd0);
    dIn[4] = 1'b1;
    waitCyc(3);
    check("R8 rearmed fires again", {31'd0, irq}, 32'd1);
  endtask

  task automatic testDisabledAndAck();
    logic [31:0] v;
    doReset();
    busWrite(5'h04, 32'h0000_0060);
    dIn[5] = 1'b1;
    waitCyc(4);
    check("R11 disabled no irq", {31'd0, irq}, 32'd0);
    busRead(5'h0C, v);
    check("R11 disabled status empty", v, 32'd0);
    busWrite(5'h10, 32'h4);
    waitCyc(2);
    check("R11 enable brings no stale event", {31'd0, irq}, 32'd0);
    dIn[6] = 1'b1;
    waitCyc(3);
    check("R12 irq with pending and enable", {31'd0, irq}, 32'd1);
    busWrite(5'h10, 32'h0);
    check("R10 disable write drops irq", {31'd0, irq}, 32'd0);
    busWrite(5'h10, 32'h4);
    waitCyc(1);
    check("R10 reenable no irq", {31'd0, irq}, 32'd0);
    busRead(5'h0C, v);
    check("R10 pending cleared", {31'd0, v[0]}, 32'd0);
  endtask

  initial begin
    #(8 * 100000);
    nFails++;
    nChecks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end

  initial begin
    testReset();
    testInputAndCtrl();
    testMaskRange();
    testOrEdges();
    testAndMode();
    testDisabledAndAck();
    $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
    $finish;
  end
endmodule